// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster. A column counter and a line counter run over limits set by registers. Windows decoded from those counters give a border-enable, a display-enable and the two sync outputs. Every axis has its own period, its own border window and display window, and its own sync start. The display start on the horizontal axis can be moved to the second half of the line.

A pixel-clock enable drives the counters. A programmable divider thins it by 4, 2 or 1, or stops it. Control bits set the polarity of each sync output, turn on interlace and turn on double scan. With interlace on, the block alternates between two fields. In the odd field, vertical sync starts half a line later. With double scan on, the line-fetch strobe marks only every second line, so each fetched line is shown twice.

Register writes use a plain write strobe with an address and data. There is no handshake, and a write always completes in the cycle it is presented. Pixel fetching and colour generation belong to other blocks.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, h_count and v_count are 0. All timing registers are 0, so border_en, display_en, line_fetch, hsync and vsync are all 0.
- R2: A write with wr_en high updates the addressed register at that clock edge, and the outputs use the new value from the next cycle on. The register addresses and their fields are:
  - 0: line period, bits 8:0
  - 1: horizontal border begin
  - 2: horizontal border end
  - 3: horizontal display begin, bits 8:0, with bit 9 as the half-line flag
  - 4: horizontal display end
  - 5: horizontal sync start
  - 8 to 13: the same six registers for the vertical axis, in the same order, bits 10:0 each
  - 14: bit 0 sets hsync polarity and bit 1 sets vsync polarity
  - 15: bit 0 turns on double scan, bit 1 turns on interlace, and bits 3:2 hold the clock select
  - A write to any other address changes nothing.
- R3: Clock select code 00 advances the column counter on every 4th cycle that has pix_ce high. Code 01 advances it on every 2nd such cycle and code 10 on every such cycle. Code 11 holds both counters.
- R4: h_count counts from 0 up to the line period and then returns to 0. v_count advances only when h_count returns to 0, and it returns to 0 after it reaches the frame period.
- R5: border_en is 1 exactly when h_count is at least the horizontal border begin and below the horizontal border end, and v_count is likewise inside the vertical border window.
- R6: display_en is 1 exactly when both counters are inside their display windows. Each window starts at the axis's display begin and ends just below its display end.
- R7: When the half-line flag is set, the horizontal display window starts at the display-begin value plus floor(line period / 2).
- R8: Each sync is active from the cycle its counter reaches sync start until the counter returns to 0. Polarity bit 1 drives the pin high while sync is active; polarity bit 0 drives it low while active.
- R9: With interlace on, the field flips each time the frame wraps, and turning interlace off clears it. In the odd field, vertical sync becomes active on the sync-start line only once h_count reaches floor(line period / 2).
- R10: line_fetch is 1 while h_count is 0 and v_count is inside the vertical display window. With double scan on, it is also required that v_count be even.
- R11: While pix_ce is low, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel clock enable, before division |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity as programmed |
| vsync | output | 1 | Vertical sync, polarity as programmed |
| border_en | output | 1 | Inside the border window on both axes |
| display_en | output | 1 | Inside the display window on both axes |
| line_fetch | output | 1 | Line-fetch strobe for the first column |
| h_count | output | 9 | Current column |
| v_count | output | 11 | Current line |

## Verification
The busiest cycle is the frame wrap. There, the column wrap, the line wrap and the field flip all fall on one clock edge. In the odd field, the delayed vertical sync and the horizontal sync are both active within the same line. The bench steps through whole frames at full rate, with interlace turned on partway through a frame. It compares every output in every cycle against a model computed from the programmed values and its own field tracking. A register write that lands mid-frame checks that the new value applies from the next cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int H_W = 9;
  localparam int V_W = 11;

  typedef struct packed {
    logic [H_W-1:0] h_tot;
    logic [H_W-1:0] h_bb;
    logic [H_W-1:0] h_be;
    logic [H_W-1:0] h_db;
    logic           h_half;
    logic [H_W-1:0] h_de;
    logic [H_W-1:0] h_ss;
    logic [V_W-1:0] v_tot;
    logic [V_W-1:0] v_bb;
    logic [V_W-1:0] v_be;
    logic [V_W-1:0] v_db;
    logic [V_W-1:0] v_de;
    logic [V_W-1:0] v_ss;
    logic           hpol;
    logic           vpol;
    logic           dbl;
    logic           ilace;
    logic [1:0]     psel;
  } rtg_cfg_t;

  typedef enum logic [3:0] {
    A_HTOT = 4'd0,  A_HBB = 4'd1,  A_HBE = 4'd2,  A_HDB = 4'd3,
    A_HDE  = 4'd4,  A_HSS = 4'd5,
    A_VTOT = 4'd8,  A_VBB = 4'd9,  A_VBE = 4'd10, A_VDB = 4'd11,
    A_VDE  = 4'd12, A_VSS = 4'd13,
    A_CTRL = 4'd14, A_MODE = 4'd15
  } rtg_addr_e;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output rtg_cfg_t      cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_HTOT: cfg.h_tot <= wr_data[H_W-1:0];
        A_HBB:  cfg.h_bb  <= wr_data[H_W-1:0];
        A_HBE:  cfg.h_be  <= wr_data[H_W-1:0];
        A_HDB: begin
          cfg.h_db   <= wr_data[H_W-1:0];
          cfg.h_half <= wr_data[H_W];
        end
        A_HDE:  cfg.h_de  <= wr_data[H_W-1:0];
        A_HSS:  cfg.h_ss  <= wr_data[H_W-1:0];
        A_VTOT: cfg.v_tot <= wr_data[V_W-1:0];
        A_VBB:  cfg.v_bb  <= wr_data[V_W-1:0];
        A_VBE:  cfg.v_be  <= wr_data[V_W-1:0];
        A_VDB:  cfg.v_db  <= wr_data[V_W-1:0];
        A_VDE:  cfg.v_de  <= wr_data[V_W-1:0];
        A_VSS:  cfg.v_ss  <= wr_data[V_W-1:0];
        A_CTRL: begin
          cfg.hpol <= wr_data[0];
          cfg.vpol <= wr_data[1];
        end
        A_MODE: begin
          cfg.dbl   <= wr_data[0];
          cfg.ilace <= wr_data[1];
          cfg.psel  <= wr_data[3:2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtg_pixdiv.sv
module rtg_pixdiv #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             halt;

  always_comb begin
    halt = 1'b0;
    case (sel)
      2'b00:   lim = CNT_W'(3);
      2'b01:   lim = CNT_W'(1);
      2'b10:   lim = '0;
      default: begin lim = '0; halt = 1'b1; end
    endcase
  end

  assign tick = ce && !halt && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || halt)  cnt <= '0;
    else if (tick)       cnt <= '0;
    else if (ce)         cnt <= cnt + 1'b1;
  end

  // R3
  div4_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == 2'b00 && $stable(sel)) |=> !tick);
  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !tick);
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] total,
  input  logic [W-1:0] bb,
  input  logic [W-1:0] be,
  input  logic [W:0]   db,
  input  logic [W-1:0] de,
  input  logic [W-1:0] ss,
  output logic [W-1:0] cnt,
  output logic         at_end,
  output logic         bwin,
  output logic         dwin,
  output logic         sact,
  output logic         s_eq
);
  assign at_end = (cnt >= total);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (adv)    cnt <= at_end ? '0 : cnt + 1'b1;
  end

  assign bwin = (cnt >= bb) && (cnt < be);
  assign dwin = ({1'b0, cnt} >= db) && (cnt < de);
  assign sact = (cnt >= ss);
  assign s_eq = (cnt == ss);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt >= total) |=> (cnt == '0));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_ce,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           hsync,
  output logic           vsync,
  output logic           border_en,
  output logic           display_en,
  output logic           line_fetch,
  output logic [H_W-1:0] h_count,
  output logic [V_W-1:0] v_count
);
  localparam logic [H_W:0] ZERO_EXT = '0;

  rtg_cfg_t cfg;
  logic     tick;
  logic     h_end, v_end, h_bw, v_bw, h_dw, v_dw, h_sa, v_sa, h_seq, v_seq;
  logic     v_adv, field;
  logic [H_W-1:0] h_half;
  logic [H_W:0]   h_db_eff;
  logic [V_W:0]   v_db_ext;
  logic     vs_act;

  rtg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg));

  rtg_pixdiv u_div (
    .clk(clk), .rst_n(rst_n), .ce(pix_ce), .sel(cfg.psel), .tick(tick));

  assign h_half   = cfg.h_tot >> 1;
  assign h_db_eff = {1'b0, cfg.h_db} + (cfg.h_half ? {1'b0, h_half} : ZERO_EXT);
  assign v_db_ext = {1'b0, cfg.v_db};
  assign v_adv    = tick && h_end;

  rtg_axis #(.W(H_W)) u_h (
    .clk(clk), .rst_n(rst_n), .adv(tick), .total(cfg.h_tot),
    .bb(cfg.h_bb), .be(cfg.h_be), .db(h_db_eff), .de(cfg.h_de),
    .ss(cfg.h_ss), .cnt(h_count), .at_end(h_end), .bwin(h_bw),
    .dwin(h_dw), .sact(h_sa), .s_eq(h_seq));

  rtg_axis #(.W(V_W)) u_v (
    .clk(clk), .rst_n(rst_n), .adv(v_adv), .total(cfg.v_tot),
    .bb(cfg.v_bb), .be(cfg.v_be), .db(v_db_ext), .de(cfg.v_de),
    .ss(cfg.v_ss), .cnt(v_count), .at_end(v_end), .bwin(v_bw),
    .dwin(v_dw), .sact(v_sa), .s_eq(v_seq));

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg.ilace)  field <= 1'b0;
    else if (v_adv && v_end)   field <= !field;
  end

  always_comb begin
    if (field) vs_act = (v_sa && !v_seq) || (v_seq && h_count >= h_half);
    else       vs_act = v_sa;
  end

  assign hsync      = cfg.hpol ? h_sa   : !h_sa;
  assign vsync      = cfg.vpol ? vs_act : !vs_act;
  assign border_en  = h_bw && v_bw;
  assign display_en = h_dw && v_dw;
  assign line_fetch = (h_count == '0) && v_dw && (!cfg.dbl || !v_count[0]);

  // R9
  field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ilace && v_adv && v_end && $stable(cfg.ilace)) |=> (field != $past(field)));
  // R10
  dbl_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dbl && line_fetch) |-> !v_count[0]);
  // R6
  disp_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    display_en |-> (h_count < cfg.h_de));
endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, pix_ce = 1, wr_en = 0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        hsync, vsync, border_en, display_en, line_fetch;
  logic [8:0]  h_count;
  logic [10:0] v_count;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int htot = 9, hbb = 1, hbe = 9, hdb = 2, hde = 8, hss = 7;
  int vtot = 5, vbb = 1, vbe = 5, vdb = 1, vde = 4, vss = 4;
  bit half = 0, hpol = 0, vpol = 0, dbl = 0, ilace = 0;

  raster_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
    .border_en(border_en), .display_en(display_en), .line_fetch(line_fetch),
    .h_count(h_count), .v_count(v_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", req, act, exp, h_count, v_count);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_mode(int sel);
    wr(15, (sel << 2) | (int'(ilace) << 1) | int'(dbl));
  endtask

  task automatic check_outputs(bit odd, string req);
    int h = int'(h_count), v = int'(v_count);
    int dbeg = hdb + (half ? htot / 2 : 0);
    bit hd = (h >= dbeg) && (h < hde);
    bit vd = (v >= vdb) && (v < vde);
    bit hs = (h >= hss);
    bit vs = odd ? ((v > vss) || (v == vss && h >= htot / 2)) : (v >= vss);
    bit eb = (h >= hbb) && (h < hbe) && (v >= vbb) && (v < vbe);
    bit lf = (h == 0) && vd && (!dbl || (v % 2 == 0));
    chk(border_en == eb, {req, "/R5 border"}, border_en, eb);
    chk(display_en == (hd && vd), {req, "/R6 display"}, display_en, hd && vd);
    chk(hsync == (hpol ? hs : !hs), {req, "/R8 hsync"}, hsync, hpol ? hs : !hs);
    chk(vsync == (vpol ? vs : !vs), {req, "/R8 vsync"}, vsync, vpol ? vs : !vs);
    chk(line_fetch == lf, {req, "/R10 fetch"}, line_fetch, lf);
  endtask

  task automatic wait_origin();
    do @(negedge clk); while (!(h_count == 0 && v_count == 0));
  endtask

  // Full-rate sweep of one frame starting at the origin; checks R4 stepping.
  task automatic sweep(bit odd, string req);
    for (int i = 0; i < (htot + 1) * (vtot + 1); i++) begin
      int ph = int'(h_count), pv = int'(v_count);
      int eh, ev;
      check_outputs(odd, req);
      @(negedge clk);
      eh = (ph >= htot) ? 0 : ph + 1;
      ev = (ph >= htot) ? ((pv >= vtot) ? 0 : pv + 1) : pv;
      chk(int'(h_count) == eh, {req, "/R4 h step"}, h_count, eh);
      chk(int'(v_count) == ev, {req, "/R4 v step"}, v_count, ev);
    end
  endtask

  task automatic program_all();
    wr(0, htot); wr(1, hbb); wr(2, hbe); wr(3, hdb | (int'(half) << 9));
    wr(4, hde); wr(5, hss);
    wr(8, vtot); wr(9, vbb); wr(10, vbe); wr(11, vdb); wr(12, vde); wr(13, vss);
    wr(14, int'(hpol) | (int'(vpol) << 1));
    wr_mode(2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(h_count == 0, "R1 h_count", h_count, 0);
    chk(v_count == 0, "R1 v_count", v_count, 0);
    chk(border_en == 0, "R1 border_en", border_en, 0);
    chk(display_en == 0, "R1 display_en", display_en, 0);
    chk(line_fetch == 0, "R1 line_fetch", line_fetch, 0);
    chk(hsync == 0, "R1 hsync", hsync, 0);
    chk(vsync == 0, "R1 vsync", vsync, 0);
  endtask

  task automatic t_basic();
    program_all();
    wait_origin();
    sweep(0, "R4 base frame");
  endtask

  task automatic t_write_timing();
    // R2: write hss mid-line, new value effective next cycle; unmapped address ignored
    wr(6, 16'h01FF);
    wr(7, 16'h0000);
    wait_origin();
    sweep(0, "R2 unmapped");
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd5; wr_data = 16'd0;
    @(negedge clk);
    wr_en = 0; hss = 0;
    chk(hsync == 0, "R2 hss next cycle", hsync, 0);
    wr(5, 7); hss = 7;
  endtask

  task automatic t_polarity();
    hpol = 1; vpol = 1;
    wr(14, 3);
    wait_origin();
    sweep(0, "R8 positive");
    hpol = 0; vpol = 0;
    wr(14, 0);
  endtask

  task automatic t_halfline();
    half = 1;
    wr(3, hdb | (1 << 9));
    wait_origin();
    sweep(0, "R7 half line");
    half = 0;
    wr(3, hdb);
  endtask

  task automatic t_dblscan();
    vdb = 0; vde = 5; dbl = 1;
    wr(11, vdb); wr(12, vde); wr_mode(2);
    wait_origin();
    sweep(0, "R10 double scan");
    dbl = 0; vdb = 1; vde = 4;
    wr(11, vdb); wr(12, vde); wr_mode(2);
  endtask

  task automatic t_interlace();
    ilace = 0; wr_mode(2);
    wait_origin();
    repeat (7) @(negedge clk);
    ilace = 1; wr_mode(2);
    wait_origin();
    sweep(1, "R9 odd field");
    sweep(0, "R9 even field");
    sweep(1, "R9 odd again");
    ilace = 0; wr_mode(2);
  endtask

  task automatic measure_period(int sel, int exp, string req);
    int n;
    logic [8:0] last;
    wr_mode(sel);
    last = h_count;
    do @(negedge clk); while (h_count == last);
    for (int k = 0; k < 2; k++) begin
      n = 0; last = h_count;
      do begin @(negedge clk); n++; end while (h_count == last && n < 50);
      chk(n == exp, req, n, exp);
    end
  endtask

  task automatic t_divider();
    logic [8:0] h0;
    logic [10:0] v0;
    measure_period(0, 4, "R3 divide 4");
    measure_period(1, 2, "R3 divide 2");
    measure_period(2, 1, "R3 divide 1");
    wr_mode(3);
    h0 = h_count; v0 = v_count;
    repeat (20) @(negedge clk);
    chk(h_count == h0, "R3 code 11 holds h", h_count, h0);
    chk(v_count == v0, "R3 code 11 holds v", v_count, v0);
    wr_mode(2);
  endtask

  task automatic t_ce_gate();
    logic [8:0] h0;
    logic [10:0] v0;
    @(negedge clk);
    pix_ce = 0;
    @(negedge clk);
    h0 = h_count; v0 = v_count;
    repeat (15) @(negedge clk);
    chk(h_count == h0, "R11 ce low holds h", h_count, h0);
    chk(v_count == v0, "R11 ce low holds v", v_count, v0);
    pix_ce = 1;
    @(negedge clk);
    chk(h_count != h0, "R11 resumes", h_count, (int'(h0) >= htot) ? 0 : h0 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_basic();
    t_write_timing();
    t_polarity();
    t_halfline();
    t_dblscan();
    t_interlace();
    t_divider();
    t_ce_gate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule